// File: doc/BRIEF.md
# Burst-of-Four Write Capture Unit

This block sits on the write side of a double-data-rate memory port. It decodes a write command on the primary clock edge and latches its address. Over the next two primary clock cycles it collects four data words, each with its own active-low lane enables. Each primary cycle carries two data phases. The first phase is presented on the rising-phase bus and the second on the falling-phase bus, each with its own enable vector.

The four words are packed into one wide word in fixed burst order. Word 0 sits in the least significant slot. A per-lane merge mask comes with it, in which a set bit means "write this lane" and a clear bit means "keep the stored lane". The wide word, the mask and the address are presented together with a single-cycle write strobe. A memory array downstream applies them as one masked write.

A command arriving on the edge that captures words 2 and 3 starts the next burst at once, so bursts can run back to back every two cycles. A command arriving on the edge that captures words 0 and 1 is dropped. A synchronous reset discards any burst still being collected.

Top module: `burst4_wr_capture`

## Requirements
- R1: A write command is accepted at a clock edge where `cmd_load_n` = 0 and `cmd_rw_n` = 0 and no capture of words 0/1 is due. `cmd_addr` is latched on that edge and appears on `wr_addr` with the commit of that burst.
- R2: Words 0 and 1 are taken from `rise_data` and `fall_data`, with `rise_be_n` and `fall_be_n`, at the first clock edge after the command edge.
- R3: Words 2 and 3 are taken from `rise_data` and `fall_data` at the second edge after the command edge. In `wr_data`, word k occupies bits [k*WORD_W +: WORD_W].
- R4: Lane enables are active low. Lane l of word k maps to `wr_mask` bit k*LANES+l, which is 1 when that lane is to be written and 0 when the stored lane must be kept. Lane l covers data bits [l*LANE_W +: LANE_W] of its word.
- R5: When every enable of one word is high, all mask bits of that word are 0, and the other words of the burst are unaffected.
- R6: `wr_stb` is high for exactly one cycle. It rises after the edge that captures words 2/3. `wr_addr`, `wr_data` and `wr_mask` change only with a commit and hold their values between commits.
- R7: A write command at the edge that captures words 0/1 is ignored and has no effect on the burst in flight. A write command at the edge that captures words 2/3 starts a new burst, giving back-to-back commits two cycles apart.
- R8: An edge with `cmd_load_n` = 1, or with `cmd_load_n` = 0 and `cmd_rw_n` = 1 (a read), starts no burst and produces no strobe.
- R9: While `rst` is high at a clock edge, the capture state is cleared, `wr_stb`, `wr_addr`, `wr_data` and `wr_mask` go to 0, and a partially collected burst is never committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_load_n | input | 1 | Command load, active low |
| cmd_rw_n | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Burst address, latched with an accepted write |
| rise_data | input | WORD_W | Rising-phase data word (burst words 0 and 2) |
| rise_be_n | input | LANES | Rising-phase lane enables, active low |
| fall_data | input | WORD_W | Falling-phase data word (burst words 1 and 3) |
| fall_be_n | input | LANES | Falling-phase lane enables, active low |
| wr_stb | output | 1 | One-cycle wide write strobe |
| wr_addr | output | ADDR_W | Address of the committed burst |
| wr_data | output | 4*WORD_W | Four words packed, word 0 in the low slot |
| wr_mask | output | 4*LANES | Per-lane write mask, 1 = write |

## Verification
The assertions take for granted that `rst` is high from time zero until at least one clock edge has passed, and that the command inputs are valid (0 or 1) at every edge outside reset. The strobe-history property looks three edges back at the command inputs, so it only holds once the command pins have real values. The bench drives every input on the falling clock edge and starts from a held reset. Unused data and enable phases are given defined values, never X, so every edge sees a clean command.

// File: rtl/b4_cap_pkg.sv
package b4_cap_pkg;

   typedef enum logic [1:0] {
      CAP_IDLE = 2'd0,
      CAP_LO   = 2'd1,
      CAP_HI   = 2'd2
   } cap_state_e;

   localparam int unsigned BURST_LEN = 4;
   localparam int unsigned PHASES    = 2;

   function automatic int unsigned lane_count(input int unsigned word_w,
                                              input int unsigned lane_w);
      return word_w / lane_w;
   endfunction

endpackage

// File: rtl/b4_cmd_decode.sv
module b4_cmd_decode
   import b4_cap_pkg::*;
#(
   parameter int unsigned ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_n,
   input  logic              rw_n,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              accept,
   output cap_state_e        state,
   output logic [ADDR_W-1:0] addr_q
);

   logic wr_req;

   assign wr_req = !load_n && !rw_n;
   // a new write is only refused while words 0/1 are due
   assign accept = wr_req && (state != CAP_LO);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= CAP_IDLE;
         addr_q <= '0;
      end else begin
         unique case (state)
            CAP_IDLE: begin
               if (accept) begin
                  state  <= CAP_LO;
                  addr_q <= addr_in;
               end
            end
            CAP_LO: begin
               state <= CAP_HI;
            end
            CAP_HI: begin
               if (accept) begin
                  state  <= CAP_LO;
                  addr_q <= addr_in;
               end else begin
                  state <= CAP_IDLE;
               end
            end
            default: begin
               state <= CAP_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/b4_lane_map.sv
module b4_lane_map
   import b4_cap_pkg::*;
#(
   parameter int unsigned WORD_W = 18,
   parameter int unsigned LANE_W = 9,
   parameter bit          SCRUB  = 1'b0,
   localparam int unsigned LANES = lane_count(WORD_W, LANE_W)
) (
   input  logic [WORD_W-1:0]          rise_d,
   input  logic [LANES-1:0]           rise_be_n,
   input  logic [WORD_W-1:0]          fall_d,
   input  logic [LANES-1:0]           fall_be_n,
   output logic [PHASES*WORD_W-1:0]   pair_d,
   output logic [PHASES*LANES-1:0]    pair_m
);

   logic [WORD_W-1:0] ph_d    [PHASES];
   logic [LANES-1:0]  ph_be_n [PHASES];

   assign ph_d[0]    = rise_d;
   assign ph_d[1]    = fall_d;
   assign ph_be_n[0] = rise_be_n;
   assign ph_be_n[1] = fall_be_n;

   for (genvar p = 0; p < PHASES; p++) begin : g_phase
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic lane_on;
         assign lane_on = !ph_be_n[p][l];
         assign pair_m[p*LANES + l] = lane_on;
         if (SCRUB) begin : g_scrub
            assign pair_d[p*WORD_W + l*LANE_W +: LANE_W] =
               lane_on ? ph_d[p][l*LANE_W +: LANE_W] : '0;
         end else begin : g_raw
            assign pair_d[p*WORD_W + l*LANE_W +: LANE_W] =
               ph_d[p][l*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/b4_commit.sv
module b4_commit
   import b4_cap_pkg::*;
#(
   parameter int unsigned WORD_W = 18,
   parameter int unsigned LANES  = 2,
   parameter int unsigned ADDR_W = 19,
   localparam int unsigned HALF_D = PHASES * WORD_W,
   localparam int unsigned HALF_M = PHASES * LANES
) (
   input  logic                        clk,
   input  logic                        rst,
   input  cap_state_e                  state,
   input  logic [ADDR_W-1:0]           addr_q,
   input  logic [HALF_D-1:0]           pair_d,
   input  logic [HALF_M-1:0]           pair_m,
   output logic                        wr_stb,
   output logic [ADDR_W-1:0]           wr_addr,
   output logic [BURST_LEN*WORD_W-1:0] wr_data,
   output logic [BURST_LEN*LANES-1:0]  wr_mask
);

   logic [HALF_D-1:0] lo_d;
   logic [HALF_M-1:0] lo_m;

   // words 0/1 wait here until words 2/3 arrive
   always_ff @(posedge clk) begin
      if (rst) begin
         lo_d <= '0;
         lo_m <= '0;
      end else if (state == CAP_LO) begin
         lo_d <= pair_d;
         lo_m <= pair_m;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         wr_mask <= '0;
      end else begin
         wr_stb <= (state == CAP_HI);
         if (state == CAP_HI) begin
            wr_addr <= addr_q;
            wr_data <= {pair_d, lo_d};
            wr_mask <= {pair_m, lo_m};
         end
      end
   end

endmodule

// File: rtl/burst4_wr_capture.sv
module burst4_wr_capture
   import b4_cap_pkg::*;
#(
   parameter int unsigned WORD_W = 18,
   parameter int unsigned LANE_W = 9,
   parameter int unsigned ADDR_W = 19,
   parameter bit          SCRUB  = 1'b0,
   localparam int unsigned LANES = lane_count(WORD_W, LANE_W)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        cmd_load_n,
   input  logic                        cmd_rw_n,
   input  logic [ADDR_W-1:0]           cmd_addr,
   input  logic [WORD_W-1:0]           rise_data,
   input  logic [LANES-1:0]            rise_be_n,
   input  logic [WORD_W-1:0]           fall_data,
   input  logic [LANES-1:0]            fall_be_n,
   output logic                        wr_stb,
   output logic [ADDR_W-1:0]           wr_addr,
   output logic [BURST_LEN*WORD_W-1:0] wr_data,
   output logic [BURST_LEN*LANES-1:0]  wr_mask
);

   if (LANE_W == 0 || WORD_W % LANE_W != 0) begin : g_bad_lane
      $error("WORD_W must be a whole multiple of a nonzero LANE_W");
   end
   if (ADDR_W == 0) begin : g_bad_addr
      $error("ADDR_W must be nonzero");
   end

   logic                        cmd_accept;
   cap_state_e                  cap_state;
   logic [ADDR_W-1:0]           addr_q;
   logic [PHASES*WORD_W-1:0]    pair_d;
   logic [PHASES*LANES-1:0]     pair_m;

   b4_cmd_decode #(
      .ADDR_W (ADDR_W)
   ) u_dec (
      .clk     (clk),
      .rst     (rst),
      .load_n  (cmd_load_n),
      .rw_n    (cmd_rw_n),
      .addr_in (cmd_addr),
      .accept  (cmd_accept),
      .state   (cap_state),
      .addr_q  (addr_q)
   );

   b4_lane_map #(
      .WORD_W (WORD_W),
      .LANE_W (LANE_W),
      .SCRUB  (SCRUB)
   ) u_map (
      .rise_d    (rise_data),
      .rise_be_n (rise_be_n),
      .fall_d    (fall_data),
      .fall_be_n (fall_be_n),
      .pair_d    (pair_d),
      .pair_m    (pair_m)
   );

   b4_commit #(
      .WORD_W (WORD_W),
      .LANES  (LANES),
      .ADDR_W (ADDR_W)
   ) u_commit (
      .clk     (clk),
      .rst     (rst),
      .state   (cap_state),
      .addr_q  (addr_q),
      .pair_d  (pair_d),
      .pair_m  (pair_m),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_mask (wr_mask)
   );

endmodule

// File: rtl/b4_wr_capture_chk.sv
module b4_wr_capture_chk #(
   parameter int unsigned DW = 72,
   parameter int unsigned MW = 8,
   parameter int unsigned AW = 19
) (
   input logic          clk,
   input logic          rst,
   input logic          cmd_load_n,
   input logic          cmd_rw_n,
   input logic          cmd_accept,
   input logic          wr_stb,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic [MW-1:0] wr_mask
);

   // R6
   stb_single_chk: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> !wr_stb);

   // R1
   stb_from_write_chk: assert property (@(posedge clk) disable iff (rst)
      wr_stb |-> ($past(cmd_load_n, 3) == 1'b0 && $past(cmd_rw_n, 3) == 1'b0));

   // R7
   no_double_accept_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_accept |=> !cmd_accept);

   // R6
   hold_between_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_stb |-> ($stable(wr_data) && $stable(wr_mask) && $stable(wr_addr)));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!wr_stb && wr_mask == '0));

endmodule

bind burst4_wr_capture b4_wr_capture_chk #(
   .DW (b4_cap_pkg::BURST_LEN * WORD_W),
   .MW (b4_cap_pkg::BURST_LEN * LANES),
   .AW (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_load_n (cmd_load_n),
   .cmd_rw_n   (cmd_rw_n),
   .cmd_accept (cmd_accept),
   .wr_stb     (wr_stb),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .wr_mask    (wr_mask)
);

// File: tb/burst4_wr_capture_tb.sv
module burst4_wr_capture_tb;

   localparam int WORD_W = 18;
   localparam int LANE_W = 9;
   localparam int ADDR_W = 19;
   localparam int LANES  = WORD_W / LANE_W;
   localparam int DW     = 4 * WORD_W;
   localparam int MW     = 4 * LANES;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              cmd_load_n = 1'b1;
   logic              cmd_rw_n = 1'b1;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [WORD_W-1:0] rise_data = '0;
   logic [LANES-1:0]  rise_be_n = '1;
   logic [WORD_W-1:0] fall_data = '0;
   logic [LANES-1:0]  fall_be_n = '1;
   logic              wr_stb;
   logic [ADDR_W-1:0] wr_addr;
   logic [DW-1:0]     wr_data;
   logic [MW-1:0]     wr_mask;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    run_cmp  = 1'b0;
   string cur_req  = "R1";

   always #5 clk = ~clk;

   burst4_wr_capture #(
      .WORD_W (WORD_W),
      .LANE_W (LANE_W),
      .ADDR_W (ADDR_W)
   ) u_dut (
      .clk        (clk),
      .rst        (rst),
      .cmd_load_n (cmd_load_n),
      .cmd_rw_n   (cmd_rw_n),
      .cmd_addr   (cmd_addr),
      .rise_data  (rise_data),
      .rise_be_n  (rise_be_n),
      .fall_data  (fall_data),
      .fall_be_n  (fall_be_n),
      .wr_stb     (wr_stb),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_mask    (wr_mask)
   );

   // behavioural reference: burst queue of collected words
   int                m_phase = 0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic [WORD_W-1:0] m_words [$];
   logic [LANES-1:0]  m_ens   [$];
   logic              exp_stb = 1'b0;
   logic [ADDR_W-1:0] exp_addr = '0;
   logic [DW-1:0]     exp_data = '0;
   logic [MW-1:0]     exp_mask = '0;
   int                n_commits = 0;

   always @(posedge clk) begin
      bit is_wr;
      is_wr = (cmd_load_n == 1'b0) && (cmd_rw_n == 1'b0);
      if (rst) begin
         m_phase = 0;
         m_words.delete();
         m_ens.delete();
         exp_stb = 1'b0;
         exp_addr = '0;
         exp_data = '0;
         exp_mask = '0;
      end else begin
         exp_stb = 1'b0;
         if (m_phase == 1 || m_phase == 2) begin
            m_words.push_back(rise_data);
            m_words.push_back(fall_data);
            m_ens.push_back(~rise_be_n);
            m_ens.push_back(~fall_be_n);
         end
         if (m_words.size() == 4) begin
            exp_stb  = 1'b1;
            exp_addr = m_addr;
            for (int k = 0; k < 4; k++) begin
               exp_data[k*WORD_W +: WORD_W] = m_words[k];
               exp_mask[k*LANES +: LANES]   = m_ens[k];
            end
            m_words.delete();
            m_ens.delete();
            n_commits++;
         end
         if (m_phase == 1) m_phase = 2;
         else if (is_wr) begin
            m_phase = 1;
            m_addr  = cmd_addr;
         end else m_phase = 0;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp) begin
         check(wr_stb === exp_stb, rst ? "R9" : (exp_stb ? "R6" : cur_req),
               "strobe", DW'(wr_stb), DW'(exp_stb));
         check(wr_addr === exp_addr, rst ? "R9" : "R1", "address",
               DW'(wr_addr), DW'(exp_addr));
         check(wr_data === exp_data, rst ? "R9" : "R2/R3 data", "data",
               wr_data, exp_data);
         check(wr_mask === exp_mask, rst ? "R9" : "R4", "mask",
               DW'(wr_mask), DW'(exp_mask));
      end
   end

   task automatic drive(input logic ld_n, input logic rw,
                        input logic [ADDR_W-1:0] a,
                        input logic [WORD_W-1:0] rd, input logic [LANES-1:0] rbe,
                        input logic [WORD_W-1:0] fd, input logic [LANES-1:0] fbe);
      @(negedge clk);
      cmd_load_n = ld_n;
      cmd_rw_n   = rw;
      cmd_addr   = a;
      rise_data  = rd;
      rise_be_n  = rbe;
      fall_data  = fd;
      fall_be_n  = fbe;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(1'b1, 1'b1, '0, '0, '1, '0, '1);
   endtask

   task automatic burst(input logic [ADDR_W-1:0] a,
                        input logic [WORD_W-1:0] w0, input logic [WORD_W-1:0] w1,
                        input logic [WORD_W-1:0] w2, input logic [WORD_W-1:0] w3,
                        input logic [LANES-1:0] b0, input logic [LANES-1:0] b1,
                        input logic [LANES-1:0] b2, input logic [LANES-1:0] b3);
      drive(1'b0, 1'b0, a, '0, '1, '0, '1);
      drive(1'b1, 1'b1, '0, w0, b0, w1, b1);
      drive(1'b1, 1'b1, '0, w2, b2, w3, b3);
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int c0;
      run_cmp = 1'b1;
      cur_req = "R9";
      idle(3);
      @(negedge clk) rst = 1'b0;
      idle(2);

      // R1 R2 R3 full burst, every lane on
      cur_req = "R1";
      burst(19'h1234a, 18'h00001, 18'h00002, 18'h00003, 18'h00004,
            2'b00, 2'b00, 2'b00, 2'b00);
      idle(3);

      // R4 mixed lane enables
      cur_req = "R4";
      burst(19'h0beef, 18'h3ffff, 18'h2aaaa, 18'h15555, 18'h0f0f0,
            2'b01, 2'b10, 2'b00, 2'b11);
      idle(2);

      // R5 whole word 2 blocked
      cur_req = "R5";
      burst(19'h00077, 18'h11111, 18'h22222, 18'h33333, 18'h04444,
            2'b00, 2'b00, 2'b11, 2'b00);
      idle(2);

      // R7 back-to-back: second command on the words 2/3 edge
      cur_req = "R7";
      c0 = n_commits;
      drive(1'b0, 1'b0, 19'h00100, '0, '1, '0, '1);
      drive(1'b1, 1'b1, '0, 18'h0aaaa, 2'b00, 18'h0bbbb, 2'b00);
      drive(1'b0, 1'b0, 19'h00200, 18'h0cccc, 2'b00, 18'h0dddd, 2'b00);
      drive(1'b1, 1'b1, '0, 18'h01111, 2'b00, 18'h02222, 2'b01);
      drive(1'b1, 1'b1, '0, 18'h03333, 2'b10, 18'h04444, 2'b00);
      idle(3);
      check(n_commits - c0 == 2, "R7", "back-to-back commits",
            DW'(n_commits - c0), DW'(2));

      // R7 command on the words 0/1 edge is ignored
      c0 = n_commits;
      drive(1'b0, 1'b0, 19'h00300, '0, '1, '0, '1);
      drive(1'b0, 1'b0, 19'h00999, 18'h05555, 2'b00, 18'h06666, 2'b00);
      drive(1'b1, 1'b1, '0, 18'h07777, 2'b00, 18'h08888, 2'b00);
      idle(4);
      check(n_commits - c0 == 1, "R7", "ignored command",
            DW'(n_commits - c0), DW'(1));

      // R8 read commands and idle edges start nothing
      cur_req = "R8";
      c0 = n_commits;
      drive(1'b0, 1'b1, 19'h00444, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00);
      drive(1'b0, 1'b1, 19'h00555, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00);
      drive(1'b1, 1'b0, 19'h00666, 18'h3ffff, 2'b00, 18'h3ffff, 2'b00);
      idle(4);
      check(n_commits == c0, "R8", "no burst on read", DW'(n_commits - c0), DW'(0));

      // R9 reset after words 0/1 drops the partial burst
      cur_req = "R9";
      c0 = n_commits;
      drive(1'b0, 1'b0, 19'h00abc, '0, '1, '0, '1);
      drive(1'b1, 1'b1, '0, 18'h12345, 2'b00, 18'h23456, 2'b00);
      rst = 1'b1;
      drive(1'b1, 1'b1, '0, 18'h34567, 2'b00, 18'h01234, 2'b00);
      drive(1'b1, 1'b1, '0, '0, '1, '0, '1);
      rst = 1'b0;
      idle(4);
      check(n_commits == c0 && wr_stb == 1'b0, "R9", "partial burst dropped",
            DW'(n_commits - c0), DW'(0));

      // mixed random traffic
      cur_req = "R6";
      for (int i = 0; i < 60; i++) begin
         logic [31:0] r;
         r = $urandom;
         drive(r[0], r[1] & r[2], ADDR_W'($urandom),
               WORD_W'($urandom), LANES'($urandom),
               WORD_W'($urandom), LANES'($urandom));
      end
      idle(4);
      run_cmp = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule